// File: doc/BRIEF.md
# Extended-Sampling Start and Conversion Trigger Controller

This block decides when a converter's sample-and-hold tracks its input and when a conversion may begin. In normal operation the serial interface's clock count sets the window. A strobe for the fourth valid serial edge opens the window, and a strobe for the tenth edge closes it, issues a hold and fires the conversion. A separate active-low start pin can instead set the acquisition time. Pulling the pin low opens a window on the channel already selected and discards the result that was waiting to be read. Releasing the pin holds the sample, and the conversion is launched two system clocks later.

A window that the pin started also sets an internal flag. Every chip-select rising edge clears this flag, and every chip-select falling edge copies it into a conversion-inhibit state. A serial cycle that opens while the flag is set only reads data out, with no sampling and no conversion. As a result, two normal serial cycles are needed after a pin-started conversion before the serial side converts again. The start pin is asynchronous, so it passes through a flop synchronizer. Its edges are ignored while a conversion is running. The chip-select edges and the serial-edge strobes arrive as single-cycle strobes that are already synchronous to the block clock.

Top module: `sample_trigger_ctrl`

## Requirements
- R1: In the idle state, an `edge4_stb` with the synchronized start pin high, `conv_inhibit` low and no conversion running raises `sample_en` after the next clock edge. A later `edge10_stb` lowers `sample_en` and pulses `hold_pulse` and `conv_start` together at the same edge.
- R2: A falling edge on `start_n_pin` is accepted when no conversion is running and the block is idle or in a normal window. Acceptance takes effect at the third clock edge after the pin changes: `sample_en` goes high (or stays high) and `result_drop` pulses for one cycle.
- R3: While the pin stays low, `sample_en` stays high. The third clock edge after the pin returns high lowers `sample_en` and pulses `hold_pulse`.
- R4: After a hold that ends a pin-started window, `conv_start` pulses exactly two clock cycles after `hold_pulse`.
- R5: `async_flag` goes high at the same edge as the hold that ends a pin-started window. A `cs_rise_stb` clears it at the next edge unless a set occurs in the same cycle, in which case the set wins.
- R6: Each `cs_fall_stb` copies `async_flag` into `conv_inhibit`, which holds that value until the next `cs_fall_stb`. While `conv_inhibit` is high, `edge4_stb` and `edge10_stb` produce no `sample_en`, no `hold_pulse` and no `conv_start`.
- R7: After a pin-started conversion, the first serial cycle (chip-select fall, then rise) is read-only. The second such cycle samples and converts.
- R8: `conv_busy` is high for CONV_CYCLES clock cycles, starting at the edge that raises `conv_start`. While it is high, start-pin edges and `edge4_stb` have no effect on `sample_en`, `result_drop` or `async_flag`.
- R9: `sample_en` and `hold_pulse` are never high together. `conv_start` is never high for two cycles in a row.
- R10: While `rst_n` is low and after its release, every output is low until an input event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n_pin | input | 1 | Asynchronous active-low start pin |
| cs_fall_stb | input | 1 | Chip-select falling-edge strobe |
| cs_rise_stb | input | 1 | Chip-select rising-edge strobe |
| edge4_stb | input | 1 | Fourth valid serial edge strobe |
| edge10_stb | input | 1 | Tenth serial edge (hold point) strobe |
| sample_en | output | 1 | Sample-and-hold tracking enable |
| hold_pulse | output | 1 | One-cycle hold command |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| conv_inhibit | output | 1 | Current serial cycle is read-only |
| result_drop | output | 1 | One-cycle discard of the pending result |
| async_flag | output | 1 | Pin-started conversion awaiting readout |
| conv_busy | output | 1 | Conversion in progress |

## Verification
A corrupted flag or inhibit state shows up one chip-select cycle later. A read-only cycle would wrongly produce a hold and a conversion, or a normal cycle would produce none, and both are visible at `conv_start` within one cycle of the tenth-edge strobe. A wrong sequencer state or busy count shows up directly. The window opens or closes at the wrong edge, `conv_start` misses its two-cycle offset from `hold_pulse`, or start-pin edges leak through while `conv_busy` is high. Each of these is visible at the ports within three clock cycles of the stimulus.

// File: rtl/sample_trigger_pkg.sv
package sample_trigger_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_NSAMP,
        PH_XSAMP,
        PH_XWAIT1,
        PH_XWAIT2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   samp;
        logic   hold;
        logic   cstart;
        logic   drop;
    } seq_state_t;

    typedef struct packed {
        logic flag;
        logic inhibit;
    } flag_state_t;

endpackage

// File: rtl/start_pin_sync.sv
module start_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level,
    output logic fall,
    output logic rise
);
    localparam int W = STAGES + 1;

    logic [W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[W-2:0], pin_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level = chain_q[W-2];
    assign fall  = chain_q[W-1] & ~chain_q[W-2];
    assign rise  = ~chain_q[W-1] & chain_q[W-2];

endmodule

// File: rtl/async_flag_track.sv
module async_flag_track
    import sample_trigger_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic cs_fall_i,
    input  logic cs_rise_i,
    output logic flag_o,
    output logic inhibit_o
);
    flag_state_t d, q;

    always_comb begin
        d = q;
        if (cs_fall_i) d.inhibit = q.flag;
        if (cs_rise_i) d.flag = 1'b0;
        if (set_i)     d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag_o    = q.flag;
    assign inhibit_o = q.inhibit;

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise_i && !set_i) |=> !flag_o);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (load_i) begin
            d.busy = 1'b1;
            d.cnt  = LAST;
        end else if (q.busy) begin
            if (q.cnt == '0) d.busy = 1'b0;
            else             d.cnt  = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;

    // R8
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

endmodule

// File: rtl/sample_seq.sv
module sample_seq
    import sample_trigger_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_fall_i,
    input  logic start_rise_i,
    input  logic start_lvl_i,
    input  logic edge4_i,
    input  logic edge10_i,
    input  logic inhibit_i,
    input  logic busy_i,
    output logic set_flag_o,
    output logic cstart_d_o,
    output logic samp_o,
    output logic hold_o,
    output logic cstart_o,
    output logic drop_o
);
    seq_state_t d, q;

    always_comb begin
        d        = q;
        d.hold   = 1'b0;
        d.cstart = 1'b0;
        d.drop   = 1'b0;
        set_flag_o = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_fall_i && !busy_i) begin
                    d.phase = PH_XSAMP;
                    d.drop  = 1'b1;
                end else if (edge4_i && start_lvl_i && !inhibit_i && !busy_i) begin
                    d.phase = PH_NSAMP;
                end
            end
            PH_NSAMP: begin
                if (start_fall_i) begin
                    d.phase = PH_XSAMP;
                    d.drop  = 1'b1;
                end else if (edge10_i) begin
                    d.phase  = PH_IDLE;
                    d.hold   = 1'b1;
                    d.cstart = 1'b1;
                end
            end
            PH_XSAMP: begin
                if (start_rise_i) begin
                    d.phase    = PH_XWAIT1;
                    d.hold     = 1'b1;
                    set_flag_o = 1'b1;
                end
            end
            PH_XWAIT1: d.phase = PH_XWAIT2;
            PH_XWAIT2: begin
                d.phase  = PH_IDLE;
                d.cstart = 1'b1;
            end
            default: d.phase = PH_IDLE;
        endcase
        d.samp = (d.phase == PH_NSAMP) || (d.phase == PH_XSAMP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, default: 1'b0};
        else        q <= d;
    end

    assign cstart_d_o = d.cstart;
    assign samp_o     = q.samp;
    assign hold_o     = q.hold;
    assign cstart_o   = q.cstart;
    assign drop_o     = q.drop;

    // R9
    samp_hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_o && hold_o));

    // R9
    cstart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cstart_o |=> !cstart_o);

    // R4
    ext_cstart_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !cstart_o) |-> ##2 cstart_o);

    // R6
    inhibit_no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE && inhibit_i && edge4_i && !start_fall_i) |=> !samp_o);

endmodule

// File: rtl/sample_trigger_ctrl.sv
module sample_trigger_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int CONV_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n_pin,
    input  logic cs_fall_stb,
    input  logic cs_rise_stb,
    input  logic edge4_stb,
    input  logic edge10_stb,
    output logic sample_en,
    output logic hold_pulse,
    output logic conv_start,
    output logic conv_inhibit,
    output logic result_drop,
    output logic async_flag,
    output logic conv_busy
);
    logic pin_lvl, pin_fall, pin_rise;
    logic set_flag, cstart_next;

    start_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (start_n_pin),
        .level (pin_lvl),
        .fall  (pin_fall),
        .rise  (pin_rise)
    );

    sample_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_fall_i (pin_fall),
        .start_rise_i (pin_rise),
        .start_lvl_i  (pin_lvl),
        .edge4_i      (edge4_stb),
        .edge10_i     (edge10_stb),
        .inhibit_i    (conv_inhibit),
        .busy_i       (conv_busy),
        .set_flag_o   (set_flag),
        .cstart_d_o   (cstart_next),
        .samp_o       (sample_en),
        .hold_o       (hold_pulse),
        .cstart_o     (conv_start),
        .drop_o       (result_drop)
    );

    async_flag_track u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_flag),
        .cs_fall_i (cs_fall_stb),
        .cs_rise_i (cs_rise_stb),
        .flag_o    (async_flag),
        .inhibit_o (conv_inhibit)
    );

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cstart_next),
        .busy_o (conv_busy)
    );

    // R8
    busy_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_busy);

endmodule

// File: tb/sample_trigger_ctrl_tb.sv
module sample_trigger_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n_pin = 1'b1;
    logic cs_fall_stb = 1'b0, cs_rise_stb = 1'b0, edge4_stb = 1'b0, edge10_stb = 1'b0;
    logic sample_en, hold_pulse, conv_start, conv_inhibit, result_drop, async_flag, conv_busy;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sample_trigger_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_n_pin  (start_n_pin),
        .cs_fall_stb  (cs_fall_stb),
        .cs_rise_stb  (cs_rise_stb),
        .edge4_stb    (edge4_stb),
        .edge10_stb   (edge10_stb),
        .sample_en    (sample_en),
        .hold_pulse   (hold_pulse),
        .conv_start   (conv_start),
        .conv_inhibit (conv_inhibit),
        .result_drop  (result_drop),
        .async_flag   (async_flag),
        .conv_busy    (conv_busy)
    );

    // {cs_fall, cs_rise, edge4, edge10, start_n, | sample_en, hold, conv_start, inhibit, flag, busy}
    localparam int NVEC = 10;
    localparam logic [10:0] VEC [NVEC] = '{
        11'b10001_000000,   // chip select falls, flag low -> no inhibit
        11'b00101_100000,   // R1 window opens
        11'b00001_100000,
        11'b00011_011001,   // R1 hold and conversion together
        11'b00001_000001,
        11'b01001_000001,   // R5 rise with flag low
        11'b00101_000001,   // R8 edge4 while busy ignored
        11'b00001_000001,
        11'b00001_000001,
        11'b00001_000000    // R8 busy lasted six cycles
    };

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, nm, act, exp);
        end
    endtask

    task automatic cyc(input logic cf, input logic cr, input logic e4, input logic e10, input logic stn);
        @(negedge clk);
        cs_fall_stb = cf;
        cs_rise_stb = cr;
        edge4_stb   = e4;
        edge10_stb  = e10;
        start_n_pin = stn;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_wait(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "sample_en", sample_en, 1'b0);
        chk("R10", "conv_start", conv_start, 1'b0);
        rst_n = 1'b1;
        idle_wait(4);
        chk("R10", "hold", hold_pulse, 1'b0);
        chk("R10", "flag", async_flag, 1'b0);
        chk("R10", "busy", conv_busy, 1'b0);
        chk("R10", "drop", result_drop, 1'b0);

        // R1 table of a normal serial cycle
        for (int i = 0; i < NVEC; i++) begin
            logic [10:0] v;
            v = VEC[i];
            cyc(v[10], v[9], v[8], v[7], v[6]);
            chk("R1", "sample_en", sample_en, v[5]);
            chk("R1", "hold", hold_pulse, v[4]);
            chk("R1", "conv_start", conv_start, v[3]);
            chk("R6", "inhibit", conv_inhibit, v[2]);
            chk("R5", "flag", async_flag, v[1]);
            chk("R8", "busy", conv_busy, v[0]);
        end

        // R2 extended window from the start pin
        cyc(0, 0, 0, 0, 0);
        chk("R2", "sample_en early", sample_en, 1'b0);
        cyc(0, 0, 0, 0, 0);
        chk("R2", "sample_en early", sample_en, 1'b0);
        cyc(0, 0, 0, 0, 0);
        chk("R2", "sample_en", sample_en, 1'b1);
        chk("R2", "drop", result_drop, 1'b1);
        cyc(0, 0, 0, 0, 0);
        chk("R2", "drop single", result_drop, 1'b0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R3", "sample_en held", sample_en, 1'b1);
        // R3 release
        cyc(0, 0, 0, 0, 1);
        chk("R3", "sample_en", sample_en, 1'b1);
        cyc(0, 0, 0, 0, 1);
        chk("R3", "hold early", hold_pulse, 1'b0);
        cyc(0, 0, 0, 0, 1);
        chk("R3", "hold", hold_pulse, 1'b1);
        chk("R3", "sample_en", sample_en, 1'b0);
        chk("R5", "flag set", async_flag, 1'b1);
        cyc(0, 0, 0, 0, 1);
        chk("R4", "conv_start early", conv_start, 1'b0);
        cyc(0, 0, 0, 0, 1);
        chk("R4", "conv_start", conv_start, 1'b1);
        chk("R8", "busy", conv_busy, 1'b1);
        cyc(0, 0, 0, 0, 1);
        chk("R9", "conv_start single", conv_start, 1'b0);

        // R8 start pin edges during conversion are ignored
        for (int k = 0; k < 3; k++) begin
            cyc(0, 0, 0, 0, 0);
            chk("R8", "sample_en", sample_en, 1'b0);
            chk("R8", "drop", result_drop, 1'b0);
        end
        for (int k = 0; k < 10; k++) begin
            cyc(0, 0, 0, 0, 1);
            chk("R8", "sample_en", sample_en, 1'b0);
            chk("R8", "drop", result_drop, 1'b0);
            chk("R8", "flag kept", async_flag, 1'b1);
        end
        chk("R8", "busy ended", conv_busy, 1'b0);

        // R6 / R7 first serial cycle is read-only
        cyc(1, 0, 0, 0, 1);
        chk("R6", "inhibit", conv_inhibit, 1'b1);
        cyc(0, 0, 1, 0, 1);
        chk("R6", "sample_en", sample_en, 1'b0);
        cyc(0, 0, 0, 1, 1);
        chk("R7", "hold", hold_pulse, 1'b0);
        chk("R7", "conv_start", conv_start, 1'b0);
        cyc(0, 1, 0, 0, 1);
        chk("R5", "flag cleared", async_flag, 1'b0);
        chk("R6", "inhibit kept", conv_inhibit, 1'b1);
        // second serial cycle converts
        cyc(1, 0, 0, 0, 1);
        chk("R7", "inhibit", conv_inhibit, 1'b0);
        cyc(0, 0, 1, 0, 1);
        chk("R7", "sample_en", sample_en, 1'b1);
        cyc(0, 0, 0, 1, 1);
        chk("R7", "hold", hold_pulse, 1'b1);
        chk("R7", "conv_start", conv_start, 1'b1);
        cyc(0, 1, 0, 0, 1);
        idle_wait(8);
        chk("R8", "busy ended", conv_busy, 1'b0);

        // R2 start pin overrides a normal window
        cyc(1, 0, 0, 0, 1);
        cyc(0, 0, 1, 0, 1);
        chk("R1", "sample_en", sample_en, 1'b1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R2", "drop early", result_drop, 1'b0);
        cyc(0, 0, 0, 0, 0);
        chk("R2", "drop override", result_drop, 1'b1);
        chk("R2", "sample_en kept", sample_en, 1'b1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R3", "hold", hold_pulse, 1'b1);
        chk("R5", "flag", async_flag, 1'b1);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R4", "conv_start", conv_start, 1'b1);
        cyc(0, 1, 0, 0, 1);
        chk("R5", "flag cleared", async_flag, 1'b0);
        idle_wait(8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule